// File: doc/BRIEF.md
# Power Stage Reset Sequencer

This block sits on the controller side of a switching power stage and drives the stage's active-low reset line. It keeps the stage in its high-impedance state until three things hold together: the gate supply has been good for a fixed precharge interval, the modulator says it is ready, and the PWM stream is really switching at a rate inside an allowed window. Only then is reset released. A matching status output shows when switching is enabled.

The PWM input is treated as synchronous to the system clock. The block measures the number of clock cycles between successive rising edges. It counts consecutive periods that fall inside the window. A period outside the window, or a gap with no rising edge as long as the slowest allowed period, clears that count. In the gap case reset also drops at once, so a PWM line stuck high or stuck low can never leave the stage enabled. A power-down request pulls reset low first and then, one cycle later, grants permission to stop the PWM.

All limits are given in system clock cycles. The defaults correspond to a 200 MHz clock, a 1 ms precharge time and a 350 to 400 kHz switching window.

Top module: `pstage_rst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `stage_rst_n` and `pwm_stop_ok` are both 0.
- R2: `stage_rst_n` rises only after `supply_ok` has been sampled high on PRECHG_CYC consecutive clock edges. When every other condition already holds, it rises on exactly the next edge after those PRECHG_CYC edges.
- R3: `stage_rst_n` is 1 only if `mod_ready` was 1 at the previous clock edge. Dropping `mod_ready` clears the reset line on the next edge.
- R4: A PWM period is the number of clock cycles from one rising edge of `pwm_in` to the next. It is valid when it lies between PER_MIN_CYC and PER_MAX_CYC inclusive. GOOD_N consecutive valid periods are required before release. A period outside the window clears `stage_rst_n` on the next edge.
- R5: When PER_MAX_CYC cycles pass with no rising edge on `pwm_in` (a stuck level), `stage_rst_n` drops on the next edge. The count of valid periods restarts from zero, and release follows again after GOOD_N fresh valid periods.
- R6: A sampled `pd_req` clears `stage_rst_n` on that edge. `pwm_stop_ok` rises one edge later, and it is 1 only while `stage_rst_n` has been 0 for the current and the previous cycle.
- R7: Loss of `supply_ok` clears `stage_rst_n` on the next edge and restarts the full precharge interval.
- R8: `switching_en` always equals `stage_rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| supply_ok | input | 1 | Gate supply is within range |
| mod_ready | input | 1 | Modulator is initialised |
| pwm_in | input | 1 | PWM stream sent to the stage, synchronous to clk |
| pd_req | input | 1 | Power-down request |
| stage_rst_n | output | 1 | Active-low reset to the power stage |
| switching_en | output | 1 | Status: stage switching is enabled |
| pwm_stop_ok | output | 1 | PWM may now be removed |

## Verification
The assertions assume that `pwm_in` is already synchronous to `clk` and changes only between edges. They also assume that the system reset is held for at least one edge before any check matters. The bench drives every input on the falling clock edge from a single generator. That generator produces a square wave of a chosen period or a constant level, so every rising edge the design sees is one that the bench itself scheduled. The period sweep runs each setting for far longer than GOOD_N periods, so each check observes settled behaviour rather than a transition.

// File: rtl/pstage_rst_seq.sv
module pstage_rst_seq #(
  parameter int PRECHG_CYC  = 200000,
  parameter int PER_MIN_CYC = 500,
  parameter int PER_MAX_CYC = 571,
  parameter int GOOD_N      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic mod_ready,
  input  logic pwm_in,
  input  logic pd_req,
  output logic stage_rst_n,
  output logic switching_en,
  output logic pwm_stop_ok
);
  localparam int PCW = $clog2(PRECHG_CYC + 1);
  localparam int PW  = $clog2(PER_MAX_CYC + 1);
  localparam int GW  = $clog2(GOOD_N + 1);

  logic [PCW-1:0] pc_cnt;
  logic [PW-1:0]  per_cnt;
  logic [GW-1:0]  good_cnt;
  logic           pwm_q, seen, run, stop_q;

  wire rise    = pwm_in & ~pwm_q;
  wire pc_done = (pc_cnt == PCW'(PRECHG_CYC));
  wire stale   = (per_cnt == PW'(PER_MAX_CYC));
  wire in_win  = seen && ({1'b0, per_cnt} >= (PW+1)'(PER_MIN_CYC - 1))
                      && (per_cnt <= PW'(PER_MAX_CYC - 1));
  wire pwm_ok  = (good_cnt == GW'(GOOD_N));
  wire permit  = supply_ok & pc_done & mod_ready & pwm_ok & ~stale & ~pd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_cnt <= '0;
    end else if (!supply_ok) begin
      pc_cnt <= '0;
    end else if (!pc_done) begin
      pc_cnt <= pc_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      per_cnt  <= '0;
      seen     <= 1'b0;
      good_cnt <= '0;
    end else begin
      pwm_q <= pwm_in;
      if (rise)        per_cnt <= '0;
      else if (!stale) per_cnt <= per_cnt + 1'b1;
      if (rise)        seen <= 1'b1;
      else if (stale)  seen <= 1'b0;
      if (stale || (rise && !in_win)) good_cnt <= '0;
      else if (rise && !pwm_ok)       good_cnt <= good_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      run    <= permit;
      stop_q <= pd_req & ~run;
    end
  end

  assign stage_rst_n  = run;
  assign switching_en = run;
  assign pwm_stop_ok  = stop_q;
endmodule

// File: rtl/pstage_rst_seq_chk.sv
module pstage_rst_seq_chk #(
  parameter int PRECHG_CYC  = 200000,
  parameter int PER_MIN_CYC = 500,
  parameter int PER_MAX_CYC = 571,
  parameter int GOOD_N      = 4
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic mod_ready,
  input logic pwm_in,
  input logic pd_req,
  input logic stage_rst_n,
  input logic switching_en,
  input logic pwm_stop_ok
);
  int   sup_run;
  int   gap;
  logic pwm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_run  <= 0;
      gap      <= 0;
      pwm_prev <= 1'b0;
    end else begin
      pwm_prev <= pwm_in;
      if (!supply_ok)                 sup_run <= 0;
      else if (sup_run <= PRECHG_CYC) sup_run <= sup_run + 1;
      if (pwm_in && !pwm_prev)        gap <= 0;
      else if (gap <= PER_MAX_CYC)    gap <= gap + 1;
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!stage_rst_n && !pwm_stop_ok)); // R1
  AST_PRECHARGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stage_rst_n |-> (sup_run > PRECHG_CYC)); // R2
  AST_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stage_rst_n |-> $past(mod_ready)); // R3
  AST_STUCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (gap > PER_MAX_CYC) |-> !stage_rst_n); // R5
  AST_PD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> !stage_rst_n); // R6
  AST_STOP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_stop_ok |-> (!stage_rst_n && $past(!stage_rst_n))); // R6
  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !stage_rst_n); // R7
  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    switching_en == stage_rst_n); // R8
endmodule

bind pstage_rst_seq pstage_rst_seq_chk #(
  .PRECHG_CYC(PRECHG_CYC), .PER_MIN_CYC(PER_MIN_CYC),
  .PER_MAX_CYC(PER_MAX_CYC), .GOOD_N(GOOD_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mod_ready(mod_ready),
  .pwm_in(pwm_in), .pd_req(pd_req), .stage_rst_n(stage_rst_n),
  .switching_en(switching_en), .pwm_stop_ok(pwm_stop_ok)
);

// File: tb/tb_pstage_rst_seq.sv
`timescale 1ns/1ps
module tb_pstage_rst_seq;
  localparam int PRECHG = 40;
  localparam int PMIN   = 10;
  localparam int PMAX   = 14;
  localparam int GOOD   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, supply_ok = 1'b0, mod_ready = 1'b0, pwm_in = 1'b0, pd_req = 1'b0;
  logic stage_rst_n, switching_en, pwm_stop_ok;
  int   errors = 0, checks = 0;
  int   pwm_mode = 0;
  int   pwm_per = 12;
  int   ph = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  pstage_rst_seq #(.PRECHG_CYC(PRECHG), .PER_MIN_CYC(PMIN), .PER_MAX_CYC(PMAX), .GOOD_N(GOOD)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mod_ready(mod_ready),
    .pwm_in(pwm_in), .pd_req(pd_req), .stage_rst_n(stage_rst_n),
    .switching_en(switching_en), .pwm_stop_ok(pwm_stop_ok));

  initial begin
    forever begin
      @(negedge clk);
      if (pwm_mode == 1) begin
        ph = (ph + 1) % pwm_per;
        pwm_in = (ph < pwm_per / 2);
      end else begin
        pwm_in = (pwm_mode == 2);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3);
    chk(stage_rst_n, 1'b0, "R1 reset held");
    chk(pwm_stop_ok, 1'b0, "R1 stop flag in reset");
    rst_n = 1'b1;
    tick(1);
    chk(stage_rst_n, 1'b0, "R1 first cycle");

    pwm_mode = 1; pwm_per = 12; mod_ready = 1'b1;
    tick(100);
    chk(stage_rst_n, 1'b0, "R2 no supply");
    supply_ok = 1'b1;
    tick(PRECHG);
    chk(stage_rst_n, 1'b0, "R2 last precharge cycle");
    tick(1);
    chk(stage_rst_n, 1'b1, "R2 release edge");
    chk(switching_en, 1'b1, "R8 status follows");

    mod_ready = 1'b0;
    tick(1);
    chk(stage_rst_n, 1'b0, "R3 ready dropped");
    chk(switching_en, 1'b0, "R8 status low");
    tick(20);
    chk(stage_rst_n, 1'b0, "R3 stays low without ready");
    mod_ready = 1'b1;
    tick(60);
    chk(stage_rst_n, 1'b1, "R3 ready restored");

    pwm_mode = 2;
    tick(PMAX + 3);
    chk(stage_rst_n, 1'b0, "R5 stuck high");
    pwm_mode = 1;
    tick(PMAX * (GOOD + 3));
    chk(stage_rst_n, 1'b1, "R5 recovered");
    pwm_mode = 0;
    tick(PMAX + 3);
    chk(stage_rst_n, 1'b0, "R5 stuck low");
    pwm_mode = 1;
    tick(PMAX * (GOOD + 3));
    chk(stage_rst_n, 1'b1, "R5 recovered from low");

    pwm_per = 8;
    tick(30);
    chk(stage_rst_n, 1'b0, "R4 fast period drops");
    pwm_per = 12;
    tick(70);
    chk(stage_rst_n, 1'b1, "R4 back in window");

    pd_req = 1'b1;
    tick(1);
    chk(stage_rst_n, 1'b0, "R6 reset first");
    chk(pwm_stop_ok, 1'b0, "R6 stop not yet");
    tick(1);
    chk(pwm_stop_ok, 1'b1, "R6 stop one cycle later");
    chk(stage_rst_n, 1'b0, "R6 reset still low");
    pd_req = 1'b0;
    tick(2);
    chk(pwm_stop_ok, 1'b0, "R6 stop cleared");
    tick(70);
    chk(stage_rst_n, 1'b1, "R6 resumes after request");

    supply_ok = 1'b0;
    tick(1);
    chk(stage_rst_n, 1'b0, "R7 supply lost");
    supply_ok = 1'b1;
    tick(PRECHG);
    chk(stage_rst_n, 1'b0, "R7 precharge restarted");
    tick(1);
    chk(stage_rst_n, 1'b1, "R7 release after precharge");

    for (int p = 6; p <= 18; p++) begin
      pwm_per = p;
      tick(200);
      chk(stage_rst_n, ((p >= PMIN) && (p <= PMAX)) ? 1'b1 : 1'b0, $sformatf("R4 sweep period %0d", p));
    end

    finish_run();
  end
endmodule